// File: doc/BRIEF.md
# Host Slave Access Decoder

This block sits behind the direct slave port through which an external host reaches the internal resources of the device. Several devices may share one chip select. Each access carries a 3-bit chip identifier, and the decoder claims the access only when that identifier equals the device's strapped ID. Two identifiers are reserved. The broadcast ID makes every device on the shared select take a write, and a read sent with it is refused. The configuration ID loads a window base register in the decoder itself.

The host address is narrow. In direct mode, the chip identifier is taken from the top three address bits and the remaining bits form the internal byte address. In sliding-window mode, the identifier comes from separate pins. The low address bits then give an offset, and the window base register supplies the upper internal address bits. Byte enables must describe an aligned group of 1, 2, 4 or 8 bytes. The data lanes, the strobes and the low address bits are then remapped for big, little or munged byte order.

Each claimed access appears one clock later as a single-cycle internal request that carries the address, the write data and the byte strobes. A refused access gives a single-cycle error pulse in the same position.

Top module: `hsad_top`

## Requirements
- R1: After reset, `req_valid` and `req_err` are 0 and the window base is 0. A sliding-window access made before any configuration write therefore yields an internal address whose upper bits are zero.
- R2: An access with `host_valid` high whose chip ID equals `strap_id` produces exactly one cycle of `req_valid` on the next clock, with `req_write` equal to `host_write`. For a read, `req_strb` is all ones. An access whose ID is neither the strap ID, 3'b110 nor 3'b111 produces neither `req_valid` nor `req_err`.
- R3: A write with chip ID 3'b110 (broadcast) is taken whatever `strap_id` is, and it is issued like an own-ID write.
- R4: A read with chip ID 3'b110 gives no request. It raises `req_err` for the single following cycle. `req_valid` and `req_err` are never high together.
- R5: When `win_mode` is 0, the chip ID is `host_addr[AW-1:AW-3]` and the internal address is `host_addr[AW-4:0]` zero-extended to IAW bits, before any munging.
- R6: When `win_mode` is 1, the chip ID is `host_cid` and the internal address is {window base, `host_addr[WOFF-1:0]`}, before any munging.
- R7: A write with chip ID 3'b111 loads the window base from `host_wdata[IAW-WOFF-1:0]`, taken from the raw bus lanes, and issues no request and no error. A read with ID 3'b111 is ignored without an error. No other access changes the window base.
- R8: A write is legal only when its byte enables are one aligned run of 1, 2, 4 or 8 ones, meaning the run length is a power of two and its lowest set bit is a multiple of that length. An illegal own-ID or broadcast write gives no request and a one-cycle `req_err`.
- R9: For `order_sel` 2'b01 (little) and 2'b11, bus byte lane i maps to internal byte i, strobe bit i maps to bit i, and the address is unchanged.
- R10: For `order_sel` 2'b00 (big), bus byte lane i goes to internal byte BW-1-i and enable bit i goes to strobe bit BW-1-i. The address is unchanged.
- R11: For `order_sel` 2'b10 (munged), data and strobes pass straight through, and the low log2(BW) internal address bits are inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_id | input | 3 | Strapped chip ID of this device (0 to 5) |
| win_mode | input | 1 | 1 selects sliding-window addressing |
| order_sel | input | 2 | Byte order: 00 big, 01 little, 10 munged, 11 little |
| host_valid | input | 1 | One-cycle host access strobe |
| host_write | input | 1 | 1 for write, 0 for read |
| host_addr | input | AW | External byte address |
| host_cid | input | 3 | Chip ID pins used in sliding-window mode |
| host_be | input | DW/8 | Byte enables, active high |
| host_wdata | input | DW | Host write data |
| req_valid | output | 1 | Internal request, one cycle |
| req_write | output | 1 | Request is a write |
| req_addr | output | IAW | Internal byte address |
| req_wdata | output | DW | Internal write data |
| req_strb | output | DW/8 | Internal byte strobes |
| req_err | output | 1 | Refused access, one cycle |

## Verification
The hardest case to reach from the ports is a sliding-window access whose address depends on a base that an earlier configuration write set. It is harder still when that write is followed by a configuration read or by accesses carrying foreign IDs, none of which may disturb the base. The stimulus first sets a known base with a directed configuration write and then reads through the window. After that, it mixes random configuration writes among random own, broadcast and foreign accesses, so that the bench's own copy of the base has to follow every load. Strap, window mode and byte order are randomized on every access, so a broadcast write is checked against many strap values, and every byte order is checked with both legal and illegal enable patterns.

// File: rtl/hsad_pkg.sv
package hsad_pkg;

    typedef enum logic [1:0] {
        ORD_BIG    = 2'b00,
        ORD_LITTLE = 2'b01,
        ORD_MUNGED = 2'b10,
        ORD_ALT    = 2'b11
    } order_e;

    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_OWN,
        CLS_BCAST,
        CLS_CFG
    } cls_e;

    localparam logic [2:0] BCAST_ID = 3'b110;
    localparam logic [2:0] CFG_ID   = 3'b111;

    // Legal when the set bits form one run whose length is a power of two
    // and whose lowest bit index is a multiple of that length.
    function automatic logic be_ok(input logic [7:0] be);
        int          cnt;
        int          lo;
        logic [15:0] run;
        cnt = $countones(be);
        lo  = 0;
        for (int i = 7; i >= 0; i--) begin
            if (be[i]) lo = i;
        end
        run = (16'd1 << cnt) - 16'd1;
        if (!(cnt == 1 || cnt == 2 || cnt == 4 || cnt == 8)) return 1'b0;
        if ((16'(be) >> lo) != run) return 1'b0;
        return ((lo % cnt) == 0);
    endfunction

endpackage

// File: rtl/hsad_classify.sv
module hsad_classify
    import hsad_pkg::*;
#(
    parameter int AW = 21
) (
    input  logic          win_mode,
    input  logic [AW-1:0] host_addr,
    input  logic [2:0]    host_cid,
    input  logic [2:0]    strap_id,
    output cls_e          cls
);
    logic [2:0] bus_id;

    assign bus_id = win_mode ? host_cid : host_addr[AW-1 -: 3];

    always_comb begin
        if (bus_id == CFG_ID)        cls = CLS_CFG;
        else if (bus_id == BCAST_ID) cls = CLS_BCAST;
        else if (bus_id == strap_id) cls = CLS_OWN;
        else                         cls = CLS_NONE;
    end
endmodule

// File: rtl/hsad_window.sv
module hsad_window #(
    parameter int WBW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [WBW-1:0] din,
    output logic [WBW-1:0] base
);
    always_ff @(posedge clk) begin
        if (rst)       base <= '0;
        else if (load) base <= din;
    end
endmodule

// File: rtl/hsad_lanes.sv
module hsad_lanes
    import hsad_pkg::*;
#(
    parameter int BW = 8
) (
    input  order_e          order,
    input  logic [BW*8-1:0] din,
    input  logic [BW-1:0]   be,
    output logic [BW*8-1:0] dout,
    output logic [BW-1:0]   strb,
    output logic            flip
);
    logic [BW*8-1:0] rev_d;
    logic [BW-1:0]   rev_be;

    for (genvar i = 0; i < BW; i++) begin : g_lane
        assign rev_d[i*8 +: 8] = din[(BW-1-i)*8 +: 8];
        assign rev_be[i]       = be[BW-1-i];
    end

    always_comb begin
        dout = din;
        strb = be;
        flip = 1'b0;
        case (order)
            ORD_BIG: begin
                dout = rev_d;
                strb = rev_be;
            end
            ORD_MUNGED: flip = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/hsad_top.sv
module hsad_top
    import hsad_pkg::*;
#(
    parameter int AW   = 21,
    parameter int DW   = 64,
    parameter int IAW  = 32,
    parameter int WOFF = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        strap_id,
    input  logic              win_mode,
    input  logic [1:0]        order_sel,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [AW-1:0]     host_addr,
    input  logic [2:0]        host_cid,
    input  logic [DW/8-1:0]   host_be,
    input  logic [DW-1:0]     host_wdata,
    output logic              req_valid,
    output logic              req_write,
    output logic [IAW-1:0]    req_addr,
    output logic [DW-1:0]     req_wdata,
    output logic [DW/8-1:0]   req_strb,
    output logic              req_err
);
    localparam int BW  = DW / 8;
    localparam int LBW = $clog2(BW);
    localparam int WBW = IAW - WOFF;
    localparam int OAW = AW - 3;

    typedef struct packed {
        logic           wr;
        logic [IAW-1:0] addr;
        logic [DW-1:0]  data;
        logic [BW-1:0]  strb;
    } req_t;

    cls_e           cls;
    logic [WBW-1:0] win_base;
    logic [DW-1:0]  lane_d;
    logic [BW-1:0]  lane_s;
    logic           flip;
    logic           legal_be;
    logic           take;
    logic           fault;
    logic           load_win;
    logic [IAW-1:0] base_addr;
    req_t           nxt;
    req_t           cur;

    hsad_classify #(.AW(AW)) u_cls (
        .win_mode (win_mode),
        .host_addr(host_addr),
        .host_cid (host_cid),
        .strap_id (strap_id),
        .cls      (cls)
    );

    hsad_window #(.WBW(WBW)) u_win (
        .clk (clk),
        .rst (rst),
        .load(load_win),
        .din (host_wdata[WBW-1:0]),
        .base(win_base)
    );

    hsad_lanes #(.BW(BW)) u_lanes (
        .order(order_e'(order_sel)),
        .din  (host_wdata),
        .be   (host_be),
        .dout (lane_d),
        .strb (lane_s),
        .flip (flip)
    );

    assign legal_be = be_ok(8'(host_be));

    always_comb begin
        take     = 1'b0;
        fault    = 1'b0;
        load_win = 1'b0;
        if (host_valid) begin
            case (cls)
                CLS_OWN: begin
                    if (!host_write || legal_be) take = 1'b1;
                    else                         fault = 1'b1;
                end
                CLS_BCAST: begin
                    if (host_write && legal_be) take = 1'b1;
                    else                        fault = 1'b1;
                end
                CLS_CFG: load_win = host_write;
                default: ;
            endcase
        end
    end

    always_comb begin
        if (win_mode) base_addr = {win_base, host_addr[WOFF-1:0]};
        else          base_addr = IAW'(host_addr[OAW-1:0]);
        nxt.wr   = host_write;
        nxt.addr = base_addr;
        if (flip) nxt.addr[LBW-1:0] = base_addr[LBW-1:0] ^ {LBW{1'b1}};
        nxt.data = lane_d;
        nxt.strb = host_write ? lane_s : {BW{1'b1}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req_err   <= 1'b0;
            cur       <= '0;
        end else begin
            req_valid <= take;
            req_err   <= fault;
            if (take) cur <= nxt;
        end
    end

    assign req_write = cur.wr;
    assign req_addr  = cur.addr;
    assign req_wdata = cur.data;
    assign req_strb  = cur.strb;
endmodule

// File: rtl/hsad_checker.sv
module hsad_checker
    import hsad_pkg::*;
#(
    parameter int AW   = 21,
    parameter int DW   = 64,
    parameter int IAW  = 32,
    parameter int WOFF = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [2:0]           strap_id,
    input logic                 win_mode,
    input logic                 host_valid,
    input logic                 host_write,
    input logic [AW-1:0]        host_addr,
    input logic [2:0]           host_cid,
    input logic                 req_valid,
    input logic                 req_err,
    input logic [DW/8-1:0]      req_strb,
    input logic [IAW-WOFF-1:0]  win_base
);
    logic       warm;
    logic [2:0] bus_id;

    always_ff @(posedge clk) begin
        if (rst) warm <= 1'b0;
        else     warm <= 1'b1;
    end

    assign bus_id = win_mode ? host_cid : host_addr[AW-1 -: 3];

    p_one_outcome_r4: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_err));

    p_req_cause_r2: assert property (@(posedge clk) disable iff (rst || !warm)
        req_valid |-> $past(host_valid));

    p_foreign_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (host_valid && bus_id != strap_id && bus_id != BCAST_ID && bus_id != CFG_ID)
        |=> (!req_valid && !req_err));

    p_bcast_read_err_r4: assert property (@(posedge clk) disable iff (rst)
        (host_valid && !host_write && bus_id == BCAST_ID) |=> (req_err && !req_valid));

    p_cfg_no_req_r7: assert property (@(posedge clk) disable iff (rst)
        (host_valid && bus_id == CFG_ID) |=> (!req_valid && !req_err));

    p_base_hold_r7: assert property (@(posedge clk) disable iff (rst || !warm)
        !(host_valid && host_write && bus_id == CFG_ID) |=> $stable(win_base));

    p_strb_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_strb != '0));
endmodule

bind hsad_top hsad_checker #(.AW(AW), .DW(DW), .IAW(IAW), .WOFF(WOFF)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .strap_id  (strap_id),
    .win_mode  (win_mode),
    .host_valid(host_valid),
    .host_write(host_write),
    .host_addr (host_addr),
    .host_cid  (host_cid),
    .req_valid (req_valid),
    .req_err   (req_err),
    .req_strb  (req_strb),
    .win_base  (win_base)
);

// File: tb/test_hsad_top.sv
`timescale 1ns/100ps
module test_hsad_top;
    localparam int AW = 21;
    localparam int DW = 64;
    localparam int IAW = 32;
    localparam int WOFF = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  strap_id;
    logic        win_mode;
    logic [1:0]  order_sel;
    logic        host_valid;
    logic        host_write;
    logic [20:0] host_addr;
    logic [2:0]  host_cid;
    logic [7:0]  host_be;
    logic [63:0] host_wdata;
    logic        req_valid;
    logic        req_write;
    logic [31:0] req_addr;
    logic [63:0] req_wdata;
    logic [7:0]  req_strb;
    logic        req_err;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;
    logic [15:0] m_base = 16'd0;

    always #2.5 clk = ~clk;

    hsad_top #(.AW(AW), .DW(DW), .IAW(IAW), .WOFF(WOFF)) i_hsad_top (
        .clk(clk), .rst(rst), .strap_id(strap_id), .win_mode(win_mode),
        .order_sel(order_sel), .host_valid(host_valid), .host_write(host_write),
        .host_addr(host_addr), .host_cid(host_cid), .host_be(host_be),
        .host_wdata(host_wdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
        .req_err(req_err)
    );

    function automatic bit legal(input logic [7:0] be);
        for (int sz = 1; sz <= 8; sz = sz * 2)
            for (int off = 0; off < 8; off = off + sz)
                if (be == 8'((((16'd1 << sz) - 1) << off))) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [63:0] rev64(input logic [63:0] d);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[i*8 +: 8] = d[(7-i)*8 +: 8];
        return r;
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    task automatic check(input string tag, input logic ev, input logic ee, input logic ew,
                         input logic [31:0] ea, input logic [63:0] ed, input logic [7:0] es);
        bit bad;
        n_chk++;
        bad = (req_valid !== ev) || (req_err !== ee);
        if (ev && !bad)
            bad = (req_write !== ew) || (req_addr !== ea) || (req_strb !== es) ||
                  (ew && req_wdata !== ed);
        if (bad) begin
            n_bad++;
            $display("FAIL %s: got v=%0b e=%0b w=%0b a=%h d=%h s=%h, expected v=%0b e=%0b w=%0b a=%h d=%h s=%h",
                     tag, req_valid, req_err, req_write, req_addr, req_wdata, req_strb,
                     ev, ee, ew, ea, ed, es);
        end
    endtask

    // Called at a falling edge; drives one access and checks it one clock later.
    task automatic access(input string tag_in, input logic wr, input logic [20:0] addr,
                          input logic [2:0] cid, input logic [7:0] be, input logic [63:0] d);
        logic [2:0]  id;
        logic        ev, ee;
        logic [31:0] ea;
        logic [63:0] ed;
        logic [7:0]  es;
        logic [15:0] nb;
        bit          ld;
        string       tag;
        id = win_mode ? cid : addr[20:18];
        ev = 0; ee = 0; ld = 0; nb = m_base;
        tag = tag_in;
        if (id == 3'b111) begin
            if (wr) begin ld = 1; nb = d[15:0]; end
            if (tag == "") tag = "R7";
        end else if (id == 3'b110) begin
            if (wr && legal(be)) ev = 1; else ee = 1;
            if (tag == "") tag = wr ? (legal(be) ? "R3" : "R8") : "R4";
        end else if (id == strap_id) begin
            if (!wr || legal(be)) ev = 1; else ee = 1;
            if (tag == "") tag = (wr && !legal(be)) ? "R8" : "R2";
        end else if (tag == "") tag = "R2";
        ea = win_mode ? {m_base, addr[15:0]} : {14'd0, addr[17:0]};
        ed = d; es = be;
        if (order_sel == 2'b00) begin ed = rev64(d); es = rev8(be); end
        if (order_sel == 2'b10) ea[2:0] = ea[2:0] ^ 3'b111;
        if (!wr) es = 8'hFF;
        host_valid = 1; host_write = wr; host_addr = addr; host_cid = cid;
        host_be = be; host_wdata = d;
        @(negedge clk);
        host_valid = 0;
        check(tag, ev, ee, wr, ea, ed, es);
        if (ld) m_base = nb;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; strap_id = 3'd2; win_mode = 0; order_sel = 2'b01;
        host_valid = 0; host_write = 0; host_addr = '0; host_cid = '0;
        host_be = '0; host_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1", 0, 0, 0, 0, 0, 0);

        // R1: window base starts at zero
        win_mode = 1;
        access("R1", 0, 21'h00_1234, 3'd2, 8'hFF, 64'd0);
        // R2: own write, then foreign ID ignored
        win_mode = 0;
        access("R2", 1, {3'd2, 18'h0_0100}, 3'd0, 8'hFF, 64'h1122_3344_5566_7788);
        access("R2", 1, {3'd4, 18'h0_0100}, 3'd0, 8'hFF, 64'h1);
        // R3: broadcast write with a different strap
        strap_id = 3'd5;
        access("R3", 1, {3'b110, 18'h0_0208}, 3'd0, 8'h0F, 64'hCAFE);
        // R4: broadcast read refused
        access("R4", 0, {3'b110, 18'h0_0208}, 3'd0, 8'hFF, 64'd0);
        // R5: direct mode address
        access("R5", 0, {3'd5, 18'h2_ABCD}, 3'd0, 8'hFF, 64'd0);
        // R7: configuration write then R6 window read
        access("R7", 1, {3'b111, 18'h0}, 3'd0, 8'hFF, 64'h0000_0000_0000_BEEF);
        win_mode = 1;
        access("R6", 0, 21'h1F_0040, 3'd5, 8'hFF, 64'd0);
        // R7: configuration read ignored, base unchanged
        access("R7", 0, 21'h0, 3'b111, 8'hFF, 64'h1234);
        access("R7", 0, 21'h00_0080, 3'd5, 8'hFF, 64'd0);
        win_mode = 0;
        // R8: enable patterns
        access("R8", 1, {3'd5, 18'h10}, 3'd0, 8'b0000_0110, 64'h55);
        access("R8", 1, {3'd5, 18'h10}, 3'd0, 8'b0000_1100, 64'h55);
        access("R8", 1, {3'd5, 18'h10}, 3'd0, 8'b0000_0101, 64'h55);
        access("R8", 1, {3'd5, 18'h10}, 3'd0, 8'b1111_0000, 64'h55);
        // R9, R10, R11: byte orders
        order_sel = 2'b01;
        access("R9", 1, {3'd5, 18'h20}, 3'd0, 8'h03, 64'h0102_0304_0506_0708);
        order_sel = 2'b11;
        access("R9", 1, {3'd5, 18'h20}, 3'd0, 8'h30, 64'h0102_0304_0506_0708);
        order_sel = 2'b00;
        access("R10", 1, {3'd5, 18'h20}, 3'd0, 8'h03, 64'h0102_0304_0506_0708);
        order_sel = 2'b10;
        access("R11", 1, {3'd5, 18'h10}, 3'd0, 8'h01, 64'h0102_0304_0506_0708);

        for (int k = 0; k < 600; k++) begin
            logic [2:0]  id;
            logic [7:0]  be;
            logic [20:0] a;
            int sz;
            strap_id  = 3'($urandom % 6);
            win_mode  = 1'($urandom % 2);
            order_sel = 2'($urandom % 4);
            case ($urandom % 5)
                0, 1:    id = strap_id;
                2:       id = 3'b110;
                3:       id = 3'b111;
                default: id = 3'($urandom % 6);
            endcase
            if ($urandom % 2 == 0) begin
                sz = 1 << ($urandom % 4);
                be = 8'(((16'd1 << sz) - 1) << (($urandom % (8 / sz)) * sz));
            end else be = 8'($urandom);
            a = 21'($urandom);
            if (!win_mode) a[20:18] = id;
            access("", 1'($urandom % 2), a, id, be, {$urandom, $urandom});
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule